// File: doc/BRIEF.md
# Single-Bit Second-Order Delta-Sigma Loop

This block is a synthesizable discrete-time model of a single-bit, second-order lowpass delta-sigma modulator. It accepts one signed fixed-point sample per enabled clock and returns one output bit per sample. The loop filter is two cascaded sections. Each section has the transfer function (1+z^-1)/(1-z^-1): its new output is its previous output plus the current and the previous input contributions. The output bit drives a two-level feedback value of plus or minus full scale. That value is held for one sample before it re-enters the loop.

The loop uses base weights d1 = 1 and d2 = 3 and leaves out the quarter-scale weight in front of the quantizer. This is possible because a sign decision does not depend on gain. The weights are placed so that the linearised noise transfer function is exactly (1-z^-1)^2. The first section sees the feedback with weight d1 = 1. The second section sees it with weight d1+d2 = 4. The quantizer sees it directly with weight d1·d2 = 3.

Both section outputs are brought out as ports so that their swing and any saturation can be observed. All sums saturate at the accumulator limits and never wrap.

Top module: `ds2_loop`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears state1, state2, every stored section input, out_bit and out_valid to zero. The held feedback bit is therefore 0, so the first sample after reset sees feedback F = -2^(IN_W-1).
- R2: out_valid is in_valid delayed by one clock. In a cycle with in_valid low, state1, state2 and out_bit keep their values.
- R3: In each accepted sample, u1 = sat(x - F) and state1 becomes sat(state1 + u1 + previous u1). Here x is the two's complement in_sample, and F is +2^(IN_W-1) when the held bit is 1 and -2^(IN_W-1) when it is 0.
- R4: In each accepted sample, u2 = sat(new state1 - 4·F) and state2 becomes sat(state2 + u2 + previous u2).
- R5: out_bit is 1 when (new state2 - 3·F) >= 0 and 0 otherwise. This bit becomes the held feedback bit for the next accepted sample, which gives a one-sample feedback delay.
- R6: sat() clamps to the signed ACC_W range, from -2^(ACC_W-1) to 2^(ACC_W-1)-1, and never wraps. This holds for a narrow ACC_W too.
- R7: With the default widths, the output pulse density tracks the input. In the mean over a window, (2·ones/N - 1)·2^(IN_W-1) follows the input mean. This holds for DC inputs and for a slow sine at an oversampling ratio of 128.
- R8: Extreme inputs, -2^(IN_W-1) and 2^(IN_W-1)-1, are accepted and processed by the same rules as any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample enable; the loop advances only when high |
| in_sample | input | IN_W | Signed two's complement input sample |
| out_valid | output | 1 | Marks a cycle whose out_bit and states come from a new sample |
| out_bit | output | 1 | Quantizer decision (1 means +full scale) |
| state1 | output | ACC_W | First section output, signed |
| state2 | output | ACC_W | Second section output, signed |

## Verification
The bench runs a behavioural model alongside the design and compares every cycle. The first samples after reset are also checked against hand-worked values. These catch a feedback polarity or initial bit that is wrong, and a feedback weight of 4 or 3 put in the wrong place. A design with either error would give a different state2 already on the first sample. A narrow second instance drives the second section into clamping, so a wrapping sum would show up as a sign flip in state2. Idle gaps in the enable stream expose a section that advances or forgets its previous input while disabled. DC and slow-sine runs check that the bit density follows the input. A loop whose noise shaping is broken would drift or lock to one level.

// File: rtl/ds2_loop.sv
module ds2_loop #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  output logic                    out_bit,
  output logic signed [ACC_W-1:0] state1,
  output logic signed [ACC_W-1:0] state2
);
  localparam int W = ACC_W + 3;
  localparam logic signed [W-1:0] FS   = W'(1) <<< (IN_W - 1);
  localparam logic signed [W-1:0] SMAX = (W'(1) <<< (ACC_W - 1)) - W'(1);
  localparam logic signed [W-1:0] SMIN = ~SMAX;

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [W-1:0] v);
    if (v > SMAX)      return SMAX[ACC_W-1:0];
    else if (v < SMIN) return SMIN[ACC_W-1:0];
    else               return v[ACC_W-1:0];
  endfunction

  function automatic logic signed [W-1:0] ext(input logic signed [ACC_W-1:0] v);
    return {{(W-ACC_W){v[ACC_W-1]}}, v};
  endfunction

  logic signed [ACC_W-1:0] s1_q, s2_q, u1_q, u2_q;
  logic                    bit_q, vld_q;

  logic signed [W-1:0]     fb, xw, qin;
  logic signed [ACC_W-1:0] u1, u2, s1_n, s2_n;

  assign fb   = bit_q ? FS : -FS;
  assign xw   = {{(W-IN_W){in_sample[IN_W-1]}}, in_sample};
  assign u1   = sat(xw - fb);
  assign s1_n = sat(ext(s1_q) + ext(u1) + ext(u1_q));
  assign u2   = sat(ext(s1_n) - (fb <<< 2));
  assign s2_n = sat(ext(s2_q) + ext(u2) + ext(u2_q));
  assign qin  = ext(s2_n) - (fb + (fb <<< 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= '0;
      s2_q  <= '0;
      u1_q  <= '0;
      u2_q  <= '0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        s1_q  <= s1_n;
        s2_q  <= s2_n;
        u1_q  <= u1;
        u2_q  <= u2;
        bit_q <= ~qin[W-1];
      end
    end
  end

  assign out_valid = vld_q;
  assign out_bit   = bit_q;
  assign state1    = s1_q;
  assign state2    = s2_q;
endmodule

// File: rtl/ds2_loop_chk.sv
module ds2_loop_chk #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic                    out_bit,
  input logic signed [ACC_W-1:0] state1,
  input logic signed [ACC_W-1:0] state2
);
  localparam int W = ACC_W + 3;
  localparam logic signed [W-1:0] FS3 = W'(3) <<< (IN_W - 1);

  logic signed [W-1:0] s2x;
  assign s2x = {{(W-ACC_W){state2[ACC_W-1]}}, state2};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (state1 == '0 && state2 == '0 && !out_bit && !out_valid));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(state1) && $stable(state2) && $stable(out_bit)));

  p_quant_rule_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bit == ((s2x - ($past(out_bit) ? FS3 : -FS3)) >= 0)));
endmodule

bind ds2_loop ds2_loop_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_bit(out_bit), .state1(state1), .state2(state2)
);

// File: tb/test_ds2_loop.sv
`timescale 1ns/1ps
module test_ds2_loop;
  localparam int IN_W = 16;
  localparam int AW   = 24;
  localparam int NW   = 17;
  localparam longint FS = 64'sd1 <<< (IN_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_sample = '0;

  logic w_ov, w_ob, n_ov, n_ob;
  logic signed [AW-1:0] w_s1, w_s2;
  logic signed [NW-1:0] n_s1, n_s2;

  ds2_loop #(.IN_W(IN_W), .ACC_W(AW)) i_ds2_loop (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(w_ov), .out_bit(w_ob), .state1(w_s1), .state2(w_s2));

  ds2_loop #(.IN_W(IN_W), .ACC_W(NW)) i_ds2_loop_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(n_ov), .out_bit(n_ob), .state1(n_s1), .state2(n_s2));

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  longint ms1[2], ms2[2], mu1[2], mu2[2], lim[2];
  bit     mb[2];
  bit     mv;
  int     satc = 0;
  int     ones = 0, nout = 0;
  real    xsum = 0.0;

  function automatic longint clip(int k, longint v);
    if (v > lim[k]) begin if (k == 1) satc++; return lim[k]; end
    if (v < -lim[k] - 1) begin if (k == 1) satc++; return -lim[k] - 1; end
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      ms1[k] = 0; ms2[k] = 0; mu1[k] = 0; mu2[k] = 0; mb[k] = 0;
    end
    mv = 0;
  endtask

  task automatic model_step(int k, longint x);
    longint f, a, b;
    f = mb[k] ? FS : -FS;
    a = clip(k, x - f);
    ms1[k] = clip(k, ms1[k] + a + mu1[k]);
    mu1[k] = a;
    b = clip(k, ms1[k] - 4 * f);
    ms2[k] = clip(k, ms2[k] + b + mu2[k]);
    mu2[k] = b;
    mb[k] = (ms2[k] - 3 * f) >= 0;
  endtask

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 out_valid", w_ov, mv);
    check("R3 state1", longint'(w_s1), ms1[0]);
    check("R4 state2", longint'(w_s2), ms2[0]);
    check("R5 out_bit", w_ob, mb[0]);
    check("R2 narrow out_valid", n_ov, mv);
    check("R6 narrow state1", longint'(n_s1), ms1[1]);
    check("R6 narrow state2", longint'(n_s2), ms2[1]);
    check("R6 narrow out_bit", n_ob, mb[1]);
    if (w_ov) begin ones += w_ob; nout++; end
  endtask

  task automatic cyc(logic v, longint x);
    @(negedge clk);
    compare_all();
    in_valid  = v;
    in_sample = IN_W'(x);
    if (v) begin model_step(0, x); model_step(1, x); xsum += real'(x); end
    mv = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    // R1: everything cleared after reset
    check("R1 state1", longint'(w_s1), 0);
    check("R1 state2", longint'(w_s2), 0);
    check("R1 out_bit", w_ob, 0);
    check("R1 out_valid", w_ov, 0);
    rst = 1'b0;
  endtask

  task automatic run_dc(longint x, real tol, string req);
    real dens, expd;
    for (int i = 0; i < 1024; i++) cyc(1, x);
    cyc(0, 0);
    ones = 0; nout = 0;
    for (int i = 0; i < 1024; i++) cyc(1, x);
    cyc(0, 0);
    dens = real'(ones) / real'(nout);
    expd = (real'(x) / real'(FS) + 1.0) / 2.0;
    tests++;
    if (dens > expd + tol || dens < expd - tol) begin
      fails++;
      $display("FAIL %s density: actual %0f expected %0f", req, dens, expd);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    lim[0] = (64'sd1 <<< (AW - 1)) - 1;
    lim[1] = (64'sd1 <<< (NW - 1)) - 1;
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // R3 R4 R5 hand-worked first samples with x = 0
    cyc(1, 0); cyc(0, 0);
    check("R3 first state1", longint'(w_s1), FS);
    check("R4 first state2", longint'(w_s2), 5 * FS);
    check("R5 first out_bit", w_ob, 1);
    cyc(1, 0); cyc(0, 0);
    check("R3 second state1", longint'(w_s1), FS);
    check("R4 second state2", longint'(w_s2), 7 * FS);
    check("R5 second out_bit", w_ob, 1);

    // R2 irregular enable with pseudo-random samples
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] | lf[3], longint'($signed(lf)) / 2);
    end
    cyc(0, 0);

    do_reset();
    run_dc(0, 0.02, "R7 dc zero");
    run_dc(FS / 2, 0.02, "R7 dc half");
    run_dc(-FS / 2, 0.02, "R7 dc minus half");

    // R7 slow sine, 4096 samples per period (inside the OSR 128 band)
    do_reset();
    for (int w = 0; w < 32; w++) begin
      real ym, xm;
      ones = 0; nout = 0; xsum = 0.0;
      for (int i = 0; i < 256; i++) begin
        int n;
        n = w * 256 + i;
        cyc(1, longint'($rtoi(0.5 * real'(FS) * $sin(6.283185307179586 * real'(n) / 4096.0))));
      end
      cyc(0, 0);
      ym = (2.0 * real'(ones) - real'(nout)) / real'(nout);
      xm = xsum / 256.0 / real'(FS);
      if (w >= 2) begin
        tests++;
        if (ym - xm > 0.06 || xm - ym > 0.06) begin
          fails++;
          $display("FAIL R7 sine window %0d: actual %0f expected %0f", w, ym, xm);
        end
      end
    end

    // R8 extreme inputs, compared exactly every cycle
    do_reset();
    for (int i = 0; i < 600; i++) cyc(1, FS - 1);
    for (int i = 0; i < 600; i++) cyc(1, -FS);
    for (int i = 0; i < 200; i++) cyc(1, (i % 2) ? FS - 1 : -FS);
    cyc(0, 0);

    // R6 the narrow instance must have clamped at least once
    tests++;
    if (satc == 0) begin
      fails++;
      $display("FAIL R6 clamp events: actual %0d expected >0", satc);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule